// File: doc/BRIEF.md
# I2C Target Byte FIFO Controller

This block links a byte-oriented I2C target engine to a processor. Bytes that the bus controller writes land in a four-entry receive queue, which software drains one byte at a time. Bytes that software loads into a four-entry transmit queue are handed to the engine each time the controller asks for one. Both fill levels are visible on status outputs.

The queues never overflow or underflow on the bus side. A byte that arrives while the receive queue is full is parked in a one-byte holding slot, and the block asks the engine to stretch the clock. A byte request that arrives while the transmit queue is empty is held open, with the clock stretched, until software writes a byte. Each received byte carries a tag bit that marks the first byte after the target was addressed. Software can therefore tell when the byte at the head of the queue is a command.

Four interrupt sources are visible as flags: a command byte at the head, a pending send request, transmit low water and receive high water. A single interrupt line is the OR of the flags that are enabled.

Top module: `i2c_tgt_fifo_ctrl`

## Requirements
- R1: The receive queue holds 4 bytes in arrival order, and `rx_level_o` gives its fill level. `sw_rdata_o` shows the head byte. When the queue is empty it shows 0x00, and a read then leaves the level unchanged.
- R2: The transmit queue holds 4 bytes, and `tx_level_o` gives its fill level. Software writes are delivered to the bus in write order.
- R3: A bus byte that arrives while the receive queue is full and no read occurs in that cycle raises `bus_wait_o` from the next cycle on. The next software read returns the old head and stores the parked byte in the same cycle, so the level stays at 4. `bus_wait_o` falls one cycle after that read.
- R4: A byte request with an empty transmit queue raises `bus_wait_o` and flag bit 1 (send request) from the next cycle on. A later software write bypasses the queue: one cycle later, `bus_tx_valid_o` pulses with that byte, and both `bus_wait_o` and flag bit 1 are low.
- R5: Flag bit 0 (command) is high exactly while the head of the receive queue is the first byte received after an `bus_addressed_i` pulse. This holds even when older bytes were queued ahead of that byte.
- R6: Flag bit 2 (transmit low water) is high while `tx_level_o` <= `cfg_tx_low_mark_i`.
- R7: Flag bit 3 (receive high water) is high while `rx_level_o` >= `cfg_rx_high_mark_i`.
- R8: `irq_o` is the OR of `irq_flags_o[i] & cfg_irq_en_i[i]` over the four flag bits.
- R9: A software write to a full transmit queue with no bus pop in that cycle is dropped and sets `tx_ovf_o`. `tx_ovf_o` stays set until reset.
- R10: A byte request with a non-empty transmit queue pops the head. `bus_tx_valid_o` pulses one cycle later with that byte on `bus_tx_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addressed_i | input | 1 | Pulse: the target was just addressed |
| bus_rx_strobe_i | input | 1 | Pulse: a byte was received from the controller |
| bus_rx_data_i | input | 8 | Received byte |
| bus_tx_req_i | input | 1 | Pulse: the controller wants a byte |
| bus_tx_data_o | output | 8 | Byte handed to the engine |
| bus_tx_valid_o | output | 1 | Pulse: `bus_tx_data_o` is valid |
| bus_wait_o | output | 1 | Clock-stretch request |
| sw_rd_i | input | 1 | Software pops one receive byte |
| sw_rdata_o | output | 8 | Receive head byte (0x00 when empty) |
| sw_wr_i | input | 1 | Software pushes one transmit byte |
| sw_wdata_i | input | 8 | Byte pushed by software |
| cfg_tx_low_mark_i | input | 3 | Transmit low-water level |
| cfg_rx_high_mark_i | input | 3 | Receive high-water level |
| cfg_irq_en_i | input | 4 | Per-flag interrupt enables |
| rx_level_o | output | 3 | Receive fill level, 0 to 4 |
| tx_level_o | output | 3 | Transmit fill level, 0 to 4 |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| irq_flags_o | output | 4 | Flag bits: 0 command, 1 send request, 2 tx low, 3 rx high |
| irq_o | output | 1 | Interrupt line |

## Verification
The receive path is driven in three ways. A short burst after addressing shows order and command-flag clearing. A burst that overfills the queue separates correct parking-and-commit from a dropped or reordered fifth byte. An unaddressed byte ahead of an addressed one shows that the command flag follows the stored tag rather than a global bit. On the transmit side, the tests cover requests against a queue holding data, requests against an empty queue, and writes past full. These separate normal popping, the bypass that closes a stretch, and the dropping of excess writes. The watermark and enable tests step the levels across the programmed marks and change the enable masks. This exposes off-by-one compares and wrong flag positions.

// File: rtl/i2ctf_pkg.sv
package i2ctf_pkg;
  localparam int FLAG_CMD    = 0;
  localparam int FLAG_SREQ   = 1;
  localparam int FLAG_TXLOW  = 2;
  localparam int FLAG_RXHIGH = 3;
  localparam int NFLAGS      = 4;

  // next pointer value, wrapping at depth
  function automatic int wrap_inc(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic logic level_le(input int lvl, input int mark);
    return lvl <= mark;
  endfunction

  function automatic logic level_ge(input int lvl, input int mark);
    return lvl >= mark;
  endfunction
endpackage

// File: rtl/i2ctf_fifo.sv
module i2ctf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          pop_ok_o
);
  import i2ctf_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok;

  assign full_o   = (count == CW'(DEPTH));
  assign empty_o  = (count == '0);
  assign pop_ok_o = pop_i && !empty_o;
  assign push_ok  = push_i && (!full_o || pop_ok_o);
  assign rdata_o  = mem[rd_ptr];
  assign level_o  = count;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok)  wr_ptr <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop_ok_o) rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok_o})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1/R2: a full queue without a pop never grows or shrinks
  a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i) |=> (level_o == CW'(DEPTH)));
endmodule

// File: rtl/i2ctf_irq.sv
module i2ctf_irq #(
  parameter int CW = 3,
  parameter int MW = 3
) (
  input  logic                       rx_empty_i,
  input  logic                       rx_head_tag_i,
  input  logic                       tx_pend_i,
  input  logic [CW-1:0]              rx_level_i,
  input  logic [CW-1:0]              tx_level_i,
  input  logic [MW-1:0]              tx_low_mark_i,
  input  logic [MW-1:0]              rx_high_mark_i,
  input  logic [i2ctf_pkg::NFLAGS-1:0] en_i,
  output logic [i2ctf_pkg::NFLAGS-1:0] flags_o,
  output logic                       irq_o
);
  import i2ctf_pkg::*;

  logic [NFLAGS-1:0] gated;

  always_comb begin
    flags_o              = '0;
    flags_o[FLAG_CMD]    = !rx_empty_i && rx_head_tag_i;
    flags_o[FLAG_SREQ]   = tx_pend_i;
    flags_o[FLAG_TXLOW]  = level_le(int'(tx_level_i), int'(tx_low_mark_i));
    flags_o[FLAG_RXHIGH] = level_ge(int'(rx_level_i), int'(rx_high_mark_i));
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_gate
    assign gated[i] = flags_o[i] & en_i[i];
  end

  assign irq_o = |gated;
endmodule

// File: rtl/i2c_tgt_fifo_ctrl.sv
module i2c_tgt_fifo_ctrl #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int MW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addressed_i,
  input  logic          bus_rx_strobe_i,
  input  logic [DW-1:0] bus_rx_data_i,
  input  logic          bus_tx_req_i,
  output logic [DW-1:0] bus_tx_data_o,
  output logic          bus_tx_valid_o,
  output logic          bus_wait_o,
  input  logic          sw_rd_i,
  output logic [DW-1:0] sw_rdata_o,
  input  logic          sw_wr_i,
  input  logic [DW-1:0] sw_wdata_i,
  input  logic [MW-1:0] cfg_tx_low_mark_i,
  input  logic [MW-1:0] cfg_rx_high_mark_i,
  input  logic [3:0]    cfg_irq_en_i,
  output logic [CW-1:0] rx_level_o,
  output logic [CW-1:0] tx_level_o,
  output logic          tx_ovf_o,
  output logic [3:0]    irq_flags_o,
  output logic          irq_o
);
  import i2ctf_pkg::*;

  // ---------------- receive path ----------------
  logic          first_q, hold_v, rx_full, rx_empty, rx_pop_ok, rx_push;
  logic [DW:0]   hold_q, rx_wdata, rx_head;
  logic          rx_tag_new, rx_new_byte, rx_commit_hold, rx_direct, rx_capture;

  assign rx_tag_new     = first_q | bus_addressed_i;
  assign rx_new_byte    = bus_rx_strobe_i && !hold_v;
  assign rx_commit_hold = hold_v && rx_pop_ok;
  assign rx_direct      = rx_new_byte && (!rx_full || rx_pop_ok);
  assign rx_capture     = rx_new_byte && rx_full && !rx_pop_ok;
  assign rx_push        = rx_commit_hold || rx_direct;
  assign rx_wdata       = hold_v ? hold_q : {rx_tag_new, bus_rx_data_i};

  i2ctf_fifo #(.W(DW + 1), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push_i(rx_push), .pop_i(sw_rd_i),
    .wdata_i(rx_wdata), .rdata_o(rx_head), .level_o(rx_level_o),
    .full_o(rx_full), .empty_o(rx_empty), .pop_ok_o(rx_pop_ok));

  assign sw_rdata_o = rx_empty ? '0 : rx_head[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      hold_v  <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (rx_new_byte)          first_q <= 1'b0;
      else if (bus_addressed_i) first_q <= 1'b1;
      if (rx_capture) begin
        hold_v <= 1'b1;
        hold_q <= {rx_tag_new, bus_rx_data_i};
      end else if (rx_commit_hold) begin
        hold_v <= 1'b0;
      end
    end
  end

  // ---------------- transmit path ----------------
  logic          tx_pend_q, tx_valid_q, tx_full, tx_empty, tx_pop_ok, ovf_q;
  logic [DW-1:0] tx_head, tx_data_q;
  logic          tx_serve, tx_bypass, tx_push, tx_drop;

  assign tx_serve  = bus_tx_req_i || tx_pend_q;
  assign tx_bypass = tx_serve && tx_empty && sw_wr_i;
  assign tx_push   = sw_wr_i && !tx_bypass;
  assign tx_drop   = tx_push && tx_full && !tx_pop_ok;

  i2ctf_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push_i(tx_push), .pop_i(tx_serve),
    .wdata_i(sw_wdata_i), .rdata_o(tx_head), .level_o(tx_level_o),
    .full_o(tx_full), .empty_o(tx_empty), .pop_ok_o(tx_pop_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend_q  <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
      ovf_q      <= 1'b0;
    end else begin
      tx_pend_q  <= tx_serve && tx_empty && !sw_wr_i;
      tx_valid_q <= tx_pop_ok || tx_bypass;
      if (tx_pop_ok)      tx_data_q <= tx_head;
      else if (tx_bypass) tx_data_q <= sw_wdata_i;
      if (tx_drop) ovf_q <= 1'b1;
    end
  end

  assign bus_tx_data_o  = tx_data_q;
  assign bus_tx_valid_o = tx_valid_q;
  assign bus_wait_o     = hold_v || tx_pend_q;
  assign tx_ovf_o       = ovf_q;

  // ---------------- flags ----------------
  i2ctf_irq #(.CW(CW), .MW(MW)) u_irq (
    .rx_empty_i(rx_empty), .rx_head_tag_i(rx_head[DW]), .tx_pend_i(tx_pend_q),
    .rx_level_i(rx_level_o), .tx_level_i(tx_level_o),
    .tx_low_mark_i(cfg_tx_low_mark_i), .rx_high_mark_i(cfg_rx_high_mark_i),
    .en_i(cfg_irq_en_i), .flags_o(irq_flags_o), .irq_o(irq_o));

  // ---------------- assertions ----------------
  a_r1_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_i && rx_level_o == '0 && !bus_rx_strobe_i) |=> (rx_level_o == '0));

  a_r3_stretch_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rx_strobe_i && !hold_v && rx_full && !sw_rd_i) |=> bus_wait_o);

  a_r3_commit_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && sw_rd_i) |=> (rx_level_o == CW'(DEPTH)) && !hold_v);

  a_r4_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tx_req_i && tx_level_o == '0 && !sw_wr_i)
      |=> (bus_wait_o && irq_flags_o[FLAG_SREQ] && !bus_tx_valid_o));

  a_r4_bypass_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pend_q && sw_wr_i) |=> (bus_tx_valid_o && !irq_flags_o[FLAG_SREQ]
                                && bus_tx_data_o == $past(sw_wdata_i)));

  a_r5_cmd_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flags_o[FLAG_CMD] |-> (rx_level_o != '0));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_o |=> tx_ovf_o);
endmodule

// File: tb/i2c_tgt_fifo_ctrl_bench.sv
module i2c_tgt_fifo_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addressed = 1'b0, bus_rx_strobe = 1'b0, bus_tx_req = 1'b0;
  logic [7:0] bus_rx_data = '0, sw_wdata = '0;
  logic       sw_rd = 1'b0, sw_wr = 1'b0;
  logic [2:0] low_mark = 3'd1, high_mark = 3'd3;
  logic [3:0] irq_en = 4'b0000;
  logic [7:0] bus_tx_data, sw_rdata;
  logic       bus_tx_valid, bus_wait, tx_ovf, irq;
  logic [2:0] rx_level, tx_level;
  logic [3:0] flags;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_tgt_fifo_ctrl u_i2c_tgt_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addressed_i(bus_addressed),
    .bus_rx_strobe_i(bus_rx_strobe), .bus_rx_data_i(bus_rx_data),
    .bus_tx_req_i(bus_tx_req), .bus_tx_data_o(bus_tx_data),
    .bus_tx_valid_o(bus_tx_valid), .bus_wait_o(bus_wait),
    .sw_rd_i(sw_rd), .sw_rdata_o(sw_rdata), .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
    .cfg_tx_low_mark_i(low_mark), .cfg_rx_high_mark_i(high_mark),
    .cfg_irq_en_i(irq_en), .rx_level_o(rx_level), .tx_level_o(tx_level),
    .tx_ovf_o(tx_ovf), .irq_flags_o(flags), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addressed();
    bus_addressed = 1'b1; @(negedge clk); bus_addressed = 1'b0;
  endtask
  task automatic rx_byte(input logic [7:0] d);
    bus_rx_data = d; bus_rx_strobe = 1'b1; @(negedge clk); bus_rx_strobe = 1'b0;
  endtask
  task automatic sw_read(output logic [7:0] d);
    d = sw_rdata; sw_rd = 1'b1; @(negedge clk); sw_rd = 1'b0;
  endtask
  task automatic sw_write(input logic [7:0] d);
    sw_wdata = d; sw_wr = 1'b1; @(negedge clk); sw_wr = 1'b0;
  endtask
  task automatic tx_req();
    bus_tx_req = 1'b1; @(negedge clk); bus_tx_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset rx level", rx_level, 0);
    check("R2 reset tx level", tx_level, 0);
    check("R3 reset wait", bus_wait, 0);
    check("R6 reset flags", flags, 4'b0100);
    check("R8 reset irq", irq, 0);
  endtask

  task automatic t_irq_mask();
    irq_en = 4'b0100; @(negedge clk);
    check("R8 txlow enabled", irq, 1);
    irq_en = 4'b1011; @(negedge clk);
    check("R8 txlow masked", irq, 0);
    irq_en = 4'b0000;
  endtask

  task automatic t_rx_basic();
    logic [7:0] d;
    addressed();
    rx_byte(8'hA1); rx_byte(8'hA2); rx_byte(8'hA3);
    check("R1 level 3", rx_level, 3);
    check("R5 cmd at head", flags[0], 1);
    check("R7 high at 3", flags[3], 1);
    sw_read(d); check("R1 first byte", d, 8'hA1);
    check("R5 cmd cleared", flags[0], 0);
    check("R7 high below mark", flags[3], 0);
    sw_read(d); check("R1 second byte", d, 8'hA2);
    sw_read(d); check("R1 third byte", d, 8'hA3);
    sw_read(d); check("R1 empty data", d, 0);
    check("R1 empty level", rx_level, 0);
  endtask

  task automatic t_rx_stretch();
    logic [7:0] d;
    rx_byte(8'h11); rx_byte(8'h22); rx_byte(8'h33); rx_byte(8'h44);
    check("R3 no wait at full", bus_wait, 0);
    rx_byte(8'hE5);
    check("R3 wait on overfill", bus_wait, 1);
    check("R3 level full", rx_level, 4);
    @(negedge clk);
    check("R3 wait held", bus_wait, 1);
    sw_read(d); check("R3 old head", d, 8'h11);
    check("R3 level stays 4", rx_level, 4);
    check("R3 wait released", bus_wait, 0);
    sw_read(d); check("R3 order 2", d, 8'h22);
    sw_read(d); check("R3 order 3", d, 8'h33);
    sw_read(d); check("R3 order 4", d, 8'h44);
    sw_read(d); check("R3 parked byte last", d, 8'hE5);
    check("R3 drained", rx_level, 0);
  endtask

  task automatic t_cmd_queued();
    logic [7:0] d;
    rx_byte(8'hB1); addressed(); rx_byte(8'hB2);
    check("R5 old byte at head", flags[0], 0);
    sw_read(d); check("R5 old byte", d, 8'hB1);
    check("R5 cmd reaches head", flags[0], 1);
    sw_read(d); check("R5 cmd byte", d, 8'hB2);
    check("R5 cmd gone", flags[0], 0);
  endtask

  task automatic t_tx_basic();
    sw_write(8'h71); sw_write(8'h72); sw_write(8'h73);
    check("R2 level 3", tx_level, 3);
    check("R6 above mark", flags[2], 0);
    tx_req();
    check("R10 valid", bus_tx_valid, 1);
    check("R10 first byte", bus_tx_data, 8'h71);
    check("R6 level 2 above mark", flags[2], 0);
    tx_req();
    check("R2 second byte", bus_tx_data, 8'h72);
    check("R6 at mark", flags[2], 1);
    tx_req();
    check("R2 third byte", bus_tx_data, 8'h73);
    check("R2 empty", tx_level, 0);
    @(negedge clk);
    check("R10 valid is a pulse", bus_tx_valid, 0);
  endtask

  task automatic t_tx_empty();
    tx_req();
    check("R4 wait", bus_wait, 1);
    check("R4 send request", flags[1], 1);
    check("R4 no data yet", bus_tx_valid, 0);
    irq_en = 4'b0010; @(negedge clk);
    check("R8 sreq irq", irq, 1);
    check("R4 still waiting", bus_wait, 1);
    sw_write(8'h5C);
    check("R4 delivered", bus_tx_valid, 1);
    check("R4 bypass data", bus_tx_data, 8'h5C);
    check("R4 wait cleared", bus_wait, 0);
    check("R4 sreq cleared", flags[1], 0);
    check("R4 queue untouched", tx_level, 0);
    irq_en = 4'b0000;
  endtask

  task automatic t_tx_ovf();
    check("R9 clear before", tx_ovf, 0);
    sw_write(8'hC0); sw_write(8'hC1); sw_write(8'hC2); sw_write(8'hC3);
    check("R9 no ovf at full", tx_ovf, 0);
    sw_write(8'hC4);
    check("R9 ovf set", tx_ovf, 1);
    check("R9 level 4", tx_level, 4);
    tx_req(); check("R9 drain 0", bus_tx_data, 8'hC0);
    tx_req(); check("R9 drain 1", bus_tx_data, 8'hC1);
    tx_req(); check("R9 drain 2", bus_tx_data, 8'hC2);
    tx_req(); check("R9 drain 3", bus_tx_data, 8'hC3);
    check("R9 dropped byte absent", tx_level, 0);
    check("R9 sticky", tx_ovf, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq_mask();
    t_rx_basic();
    t_rx_stretch();
    t_cmd_queued();
    t_tx_basic();
    t_tx_empty();
    t_tx_ovf();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule